// File: doc/BRIEF.md
# Dual Buffered-Duty Pulse Width Modulator

This block holds two independent pulse width modulation channels. Each channel runs a 10-bit up-counter at a divided rate of the block clock and compares it with an 8-bit period value and a 10-bit duty value. The channel restarts its cycle when the counter reaches the period. At that moment the output rises, the counter clears and an interrupt flag is raised. The output falls when the counter reaches the duty value that was captured at the start of the cycle.

Software writes the duty value through a byte-wide register port at any time. The value is held in a staging register. It moves into a read-only duty latch only at the next period match, so a cycle that is already running is never cut short or stretched. Each channel has two enables. One runs or freezes the counter. The other hands the pin to the modulator and drives its output enable. With the second enable off, the pin belongs to general-purpose logic outside this block.

Register writes use `wr_en`, `wr_addr` and `wr_data`. Address 0 is the control byte. For channel c, address 1+3c is the period, address 2+3c is the duty low byte and address 3+3c holds the two duty high bits in bits [1:0].

Top module: `dual_pwm`

## Requirements
- R1: The duty value is 10 bits, made from the low byte and the two high bits. The duty latch of channel c is presented at `dlat_o[10c+9:10c]`.
- R2: Control bits [5:4] (channel 0) and [7:6] (channel 1) select the counter rate: 00 divides the clock by 2, 01 by 8, 10 by 32 and 11 by 64. The counter advances once per divided tick.
- R3: A full cycle lasts (P+1) ticks, where P is the period. On the tick when the counter equals P, the counter clears, the staged duty is copied into the latch, the interrupt flag is set, and the output goes high if the new duty is nonzero.
- R4: For 0 < D < P, the output falls on the tick when the counter reaches the latched duty D, so it stays high for D ticks.
- R5: A duty write has no effect on the current cycle or on the latch until the next period match. The latch itself has no write address.
- R6: The flag of channel c stays set until a pulse on `irq_clr[c]`. A new match in the same cycle wins over the clear.
- R7: Control bit c (timer enable) at 0 freezes the counter and divider of channel c. While frozen there are no matches, no new flags and no output changes.
- R8: Control bit 2+c (modulator enable) drives `pwm_oe[c]`. While it is 0, `pwm_o[c]` is held at 0, but the timer and flag keep running.
- R9: After reset, all registers, counters, latches, flags and outputs are 0.
- R10: A latched duty greater than or equal to the period keeps the output high for the whole cycle. A latched duty of 0 keeps it low.
- R11: The two channels run independently, each with its own period, duty and rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_clr | input | 2 | Per-channel flag clear pulse |
| pwm_o | output | 2 | Modulated outputs |
| pwm_oe | output | 2 | Per-channel pin output enables |
| irq_flag | output | 2 | Per-channel period flags |
| dlat_o | output | 20 | Read-only duty latches, 10 bits per channel |

## Verification
The hardest case to reach is a duty write that lands inside a running cycle. To hit it, the monitor signals when it has seen a rising edge and started measuring. The driver then writes a new duty a few clocks into that high phase. It expects the measured cycle to keep the old high time and the following cycle to carry the new one. It also reads the latch before and after the match. Freezing uses a similar approach: the flag is cleared while the timer is stopped, and a long wait then shows that neither the flag nor the output moves.

// File: rtl/dual_pwm_pkg.sv
package dual_pwm_pkg;
  localparam int NCH    = 2;
  localparam int PSC_W  = 6;
  localparam int DATA_W = 8;

  // divide ratios 2, 8, 32, 64 expressed as terminal counts
  function automatic logic [PSC_W-1:0] psc_lim(input logic [1:0] sel);
    case (sel)
      2'd0:    return PSC_W'(1);
      2'd1:    return PSC_W'(7);
      2'd2:    return PSC_W'(31);
      default: return PSC_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import dual_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PSC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q >= psc_lim(sel));
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import dual_pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ten,
  input  logic [1:0]       psel,
  input  logic [PER_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             clr,
  output logic             out,
  output logic             flag,
  output logic [CNT_W-1:0] dlat,
  output logic [CNT_W-1:0] tmr,
  output logic             tick,
  output logic             match
);
  logic [CNT_W-1:0] tmr_q, tmr_d, lat_q, lat_d, per_ext, tmr_inc;
  logic             out_q, out_d, flg_q, flg_d;

  pwm_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ten),
    .sel  (psel),
    .tick (tick)
  );

  always_comb begin
    per_ext = {{(CNT_W-PER_W){1'b0}}, period};
    tmr_inc = tmr_q + 1'b1;
    match   = tick && (tmr_q == per_ext);
    tmr_d   = tmr_q;
    lat_d   = lat_q;
    out_d   = out_q;
    flg_d   = flg_q & ~clr;
    if (match) begin
      tmr_d = '0;
      lat_d = duty;
      out_d = (duty != '0);
      flg_d = 1'b1;
    end else if (tick) begin
      tmr_d = tmr_inc;
      if ((tmr_inc == lat_q) && (lat_q < per_ext)) out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      lat_q <= '0;
      out_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      lat_q <= lat_d;
      out_q <= out_d;
      flg_q <= flg_d;
    end
  end

  assign out  = out_q;
  assign flag = flg_q;
  assign dlat = lat_q;
  assign tmr  = tmr_q;
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import dual_pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PER_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NCH-1:0]        irq_clr,
  output logic [NCH-1:0]        pwm_o,
  output logic [NCH-1:0]        pwm_oe,
  output logic [NCH-1:0]        irq_flag,
  output logic [NCH*CNT_W-1:0]  dlat_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0]                ctrl_q, ctrl_d;
  logic [NCH-1:0][PER_W-1:0]        per_q, per_d;
  logic [NCH-1:0][CNT_W-1:0]        dut_q, dut_d;
  logic [NCH-1:0]                   ten_v, pen_v, out_v, tick_v, match_v;
  logic [NCH-1:0][CNT_W-1:0]        tmr_v;

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    dut_d  = dut_q;
    if (wr_en) begin
      if (wr_addr == '0) ctrl_d = wr_data;
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == ADDR_W'(1 + 3*c)) per_d[c] = wr_data[PER_W-1:0];
        if (wr_addr == ADDR_W'(2 + 3*c)) dut_d[c][DATA_W-1:0] = wr_data;
        if (wr_addr == ADDR_W'(3 + 3*c)) dut_d[c][CNT_W-1:DATA_W] = wr_data[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      dut_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
      dut_q  <= dut_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ten_v[c] = ctrl_q[c];
    assign pen_v[c] = ctrl_q[NCH + c];

    pwm_channel #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .ten   (ten_v[c]),
      .psel  (ctrl_q[2*NCH + 2*c +: 2]),
      .period(per_q[c]),
      .duty  (dut_q[c]),
      .clr   (irq_clr[c]),
      .out   (out_v[c]),
      .flag  (irq_flag[c]),
      .dlat  (dlat_o[c*CNT_W +: CNT_W]),
      .tmr   (tmr_v[c]),
      .tick  (tick_v[c]),
      .match (match_v[c])
    );

    assign pwm_o[c]  = out_v[c] & pen_v[c];
    assign pwm_oe[c] = pen_v[c];
  end
endmodule

// File: rtl/dual_pwm_chk.sv
module dual_pwm_chk
  import dual_pwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             ten_v,
  input logic [NCH-1:0]             tick_v,
  input logic [NCH-1:0]             match_v,
  input logic [NCH-1:0][CNT_W-1:0]  tmr_v,
  input logic [NCH-1:0]             irq_clr,
  input logic [NCH-1:0]             irq_flag,
  input logic [NCH-1:0]             pwm_o,
  input logic [NCH-1:0]             pwm_oe,
  input logic [NCH*CNT_W-1:0]       dlat_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5
    latch_only_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dlat_o[c*CNT_W +: CNT_W]) |-> $past(match_v[c]));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[c] && !irq_clr[c]) |=> irq_flag[c]);
    // R7
    frozen_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ten_v[c] |=> $stable(tmr_v[c]));
    // R7
    no_tick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ten_v[c] |-> !tick_v[c]);
    // R8
    pin_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe[c] |-> !pwm_o[c]);
    // R3
    match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_v[c] |=> (irq_flag[c] && tmr_v[c] == '0));
  end
endmodule

bind dual_pwm dual_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ten_v   (ten_v),
  .tick_v  (tick_v),
  .match_v (match_v),
  .tmr_v   (tmr_v),
  .irq_clr (irq_clr),
  .irq_flag(irq_flag),
  .pwm_o   (pwm_o),
  .pwm_oe  (pwm_oe),
  .dlat_o  (dlat_o)
);

// File: tb/dual_pwm_bench.sv
module dual_pwm_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] irq_clr;
  logic [1:0] pwm_o, pwm_oe, irq_flag;
  logic [19:0] dlat_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { int hi; int tot; string req; } exp_t;
  exp_t q0[$];
  exp_t q1[$];
  bit meas0 = 0;
  bit meas1 = 0;

  always #10 clk = ~clk;

  dual_pwm u_dual_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_clr(irq_clr), .pwm_o(pwm_o),
    .pwm_oe(pwm_oe), .irq_flag(irq_flag), .dlat_o(dlat_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int per, input int duty);
    wr(3'(1 + 3*ch), 8'(per));
    wr(3'(2 + 3*ch), 8'(duty & 8'hFF));
    wr(3'(3 + 3*ch), 8'(duty >> 8));
  endtask

  task automatic wait_empty();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor: measures high and total clocks rise-to-rise
  task automatic monitor(input int ch);
    bit prev = 0;
    bit meas = 0;
    int hi = 0;
    int tot = 0;
    forever begin
      @(negedge clk);
      if (pwm_o[ch] && !prev) begin
        if (meas) begin
          exp_t e;
          e = (ch == 0) ? q0.pop_front() : q1.pop_front();
          check({e.req, " high"}, hi, e.hi);
          check({e.req, " cycle"}, tot, e.tot);
        end
        meas = (ch == 0) ? (q0.size() > 0) : (q1.size() > 0);
        hi = 0; tot = 0;
        if (ch == 0) meas0 = meas; else meas1 = meas;
      end
      if (meas) begin
        tot++;
        if (pwm_o[ch]) hi++;
      end
      prev = pwm_o[ch];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial fork
    monitor(0);
    monitor(1);
  join_none

  initial begin
    int stuck;
    logic p0;
    wr_en = 0; wr_addr = 0; wr_data = 0; irq_clr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 pwm_o", pwm_o, 0);
    check("R9 pwm_oe", pwm_oe, 0);
    check("R9 flags", irq_flag, 0);
    check("R9 latch", dlat_o, 0);
    rst_n = 1'b1;

    // R4 R11: ch0 P=9 /2 D=4 ; ch1 P=5 /8 D=2
    cfg(0, 9, 4);
    cfg(1, 5, 2);
    q0.push_back('{8, 20, "R4 ch0"});
    q0.push_back('{8, 20, "R3 ch0"});
    q1.push_back('{16, 48, "R11 ch1"});
    wr(0, 8'h4F);
    check("R8 oe on", pwm_oe, 3);
    wait_empty();
    check("R1 ch1 latch", dlat_o[19:10], 2);

    // R2 divide by 64
    do_reset();
    cfg(0, 3, 1);
    q0.push_back('{64, 256, "R2 div64"});
    wr(0, 8'h35);
    wait_empty();
    // R2 divide by 32
    do_reset();
    cfg(0, 4, 2);
    q0.push_back('{64, 160, "R2 div32"});
    wr(0, 8'h25);
    wait_empty();

    // R5 buffered duty
    do_reset();
    cfg(0, 9, 4);
    q0.push_back('{8, 20, "R5 old duty"});
    q0.push_back('{12, 20, "R5 new duty"});
    wr(0, 8'h05);
    while (!meas0) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(3'd2, 8'd6);
    check("R5 latch held", dlat_o[9:0], 4);
    wait_empty();
    check("R5 latch updated", dlat_o[9:0], 6);

    // R1 R10: 10-bit duty above period stays high
    wr(3'd3, 8'h02);
    wr(3'd2, 8'hA5);
    repeat (30) @(negedge clk);
    check("R1 10-bit latch", dlat_o[9:0], 10'h2A5);
    stuck = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!pwm_o[0]) stuck++;
    end
    check("R10 full high", stuck, 0);

    // R6 R7 freeze and clear
    check("R6 flag set", irq_flag[0], 1);
    wr(0, 8'h04);
    repeat (2) @(negedge clk);
    p0 = pwm_o[0];
    irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 2'b00;
    check("R6 flag cleared", irq_flag[0], 0);
    repeat (200) @(negedge clk);
    check("R7 no flag frozen", irq_flag[0], 0);
    check("R7 output frozen", pwm_o[0], p0);
    check("R7 latch frozen", dlat_o[9:0], 10'h2A5);

    // R10 duty zero
    do_reset();
    cfg(0, 9, 0);
    wr(0, 8'h05);
    stuck = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_o[0]) stuck++;
    end
    check("R10 zero duty low", stuck, 0);
    check("R3 match flag", irq_flag[0], 1);

    // R8 modulator disabled, timer running
    do_reset();
    cfg(0, 9, 4);
    wr(0, 8'h01);
    stuck = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_o[0] || pwm_oe[0]) stuck++;
    end
    check("R8 pin released", stuck, 0);
    check("R8 flag still set", irq_flag[0], 1);
    check("R3 latch copied", dlat_o[9:0], 4);

    summary();
  end
endmodule